// File: doc/BRIEF.md
# Data-Ready Triggered Serial Capture Sequencer

This block waits for an external converter or sensor to announce fresh data on an active-low ready line, then reads one fixed-length frame from it over a receive-only SPI link. The ready line is asynchronous to the system clock. It passes through a synchroniser, and only a high-to-low transition starts work. Holding the line low does nothing more.

A start flag is set by that transition and cleared when the sequencer goes back to rest. One clocked process owns the flag, so it has a single driver. The sequencer is a Moore machine. It drops chip select, produces `FRAME_BITS` serial clock periods and shifts the input line into a word, most significant bit first. It then raises chip select, pulses a done strobe for one cycle and returns to rest.

Top module: `drdy_capture_seq`

## Requirements
- R1: While reset is held (synchronous, active low) and on the first cycle after it, `cs_n` is 1, `sclk` is 0, `rx_done` is 0 and `rx_word` is all zeros.
- R2: When `drdy_n` is first sampled low after being high, `cs_n` goes low after the third clock edge following that sample. This allows two synchroniser stages and one edge for the start flag.
- R3: Holding `drdy_n` low starts exactly one burst, however long the level stays low.
- R4: A burst has exactly `FRAME_BITS` rising edges of `sclk`. Each high phase and each low phase lasts `HALF_DIV` system clocks, and `sclk` starts low.
- R5: `miso` is sampled on the system clock edge where `sclk` rises. The first sampled bit ends up in `rx_word[FRAME_BITS-1]` and the last one in `rx_word[0]`.
- R6: The falling `sclk` edge of the last bit ends the burst. On the next cycle `cs_n` is 1 and `rx_done` is 1 for exactly one cycle, and `rx_word` holds the complete frame.
- R7: A falling edge on `drdy_n` whose detection falls during a burst or its done cycle is ignored and starts no later burst.
- R8: After the machine has returned to rest, the next falling edge of `drdy_n` starts a new burst. This includes an edge that arrives right at the done cycle.
- R9: `sclk` is 0 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drdy_n | input | 1 | Asynchronous data-ready line from the peripheral, active low |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Generated serial clock |
| cs_n | output | 1 | Chip select, low during a burst |
| rx_word | output | FRAME_BITS | Captured frame, first bit in the MSB |
| rx_done | output | 1 | One-cycle strobe when a frame is complete |

## Verification
The bench builds the block with its default values: a 96-bit frame, two system clocks per serial clock phase and two synchroniser stages. With these values a full-length burst of 384 cycles fits many times into the run. The run covers back-to-back bursts, a ready line held low for longer than two bursts, ready edges in the middle of a burst, and an edge placed exactly on the done cycle. The reference model follows the ready line through its own sample history. It checks chip select, serial clock, the done strobe and the whole captured word on every cycle.

// File: rtl/drc_pkg.sv
// Shared types for the data-ready capture sequencer.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package drc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/drc_sync_fall.sv
// Synchronises an asynchronous active-low line into clk and flags
// a high-to-low transition for one cycle.
// Assumes STAGES >= 2 and a line that stays put for at least a few clocks.
module drc_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Metastability chain followed by one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_n};
            prev  <= chain[STAGES-1];
        end
    end

    // Transition: settled value was high and is now low.
    assign fall = prev & ~chain[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);  // R3
endmodule

// File: rtl/drc_sclk_gen.sv
// Generates the serial clock for one burst and counts its bits.
// Assumes run stays high from burst start until the cycle after burst_end.
module drc_sclk_gen #(
    parameter int FRAME_BITS = 96,
    parameter int HALF_DIV   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_en,
    output logic burst_end
);
    localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [PW-1:0] PH_LAST  = PW'(HALF_DIV - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(FRAME_BITS - 1);

    logic [PW-1:0] ph;
    logic [CW-1:0] bit_cnt;
    logic          tick;

    assign tick      = run && (ph == PH_LAST);
    assign rise_en   = tick && !sclk;
    assign burst_end = tick && sclk && (bit_cnt == BIT_LAST);

    // Phase divider, serial clock toggle and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph      <= '0;
            sclk    <= 1'b0;
            bit_cnt <= '0;
        end else begin
            ph <= tick ? '0 : ph + 1'b1;
            if (tick) begin
                sclk <= ~sclk;
                if (sclk)
                    bit_cnt <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
            end
        end
    end

    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BIT_LAST);  // R4
    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);  // R9
endmodule

// File: rtl/drc_shift_in.sv
// Serial-in, parallel-out register that shifts towards the MSB.
// Assumes the enable is a single-cycle pulse per bit.
module drc_shift_in #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    // First bit in ends up in the MSB after WIDTH shifts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (en)
            word <= {word[WIDTH-2:0], din};
    end

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> word[0] == $past(din));  // R5
endmodule

// File: rtl/drdy_capture_seq.sv
// Moore sequencer that reads one serial frame per falling edge of the
// data-ready line. One process owns the start flag: the edge sets it,
// the done state clears it.
// Assumes the peripheral drives miso stably around rising sclk.
module drdy_capture_seq #(
    parameter int FRAME_BITS  = 96,
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  drdy_n,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  cs_n,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_done
);
    import drc_pkg::*;

    seq_state_t state;
    logic       fall;
    logic       start_flag;
    logic       rise_en;
    logic       burst_end;
    logic       run;

    drc_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (drdy_n),
        .fall  (fall)
    );

    drc_sclk_gen #(.FRAME_BITS(FRAME_BITS), .HALF_DIV(HALF_DIV)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sclk      (sclk),
        .rise_en   (rise_en),
        .burst_end (burst_end)
    );

    drc_shift_in #(.WIDTH(FRAME_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rise_en),
        .din   (miso),
        .word  (rx_word)
    );

    // Start flag: set by a detected edge at rest, cleared on the way back to rest.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_flag <= 1'b0;
        else if (state == ST_DONE)
            start_flag <= 1'b0;
        else if (state == ST_IDLE && fall)
            start_flag <= 1'b1;
    end

    // State register: rest, burst, one done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else begin
            case (state)
                ST_IDLE: if (start_flag) state <= ST_RUN;
                ST_RUN:  if (burst_end)  state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Moore outputs decoded from the state register only.
    assign run     = (state == ST_RUN);
    assign cs_n    = (state != ST_RUN);
    assign rx_done = (state == ST_DONE);

    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_flag) |=> (state == ST_RUN));  // R2
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);  // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);  // R6
    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(state == ST_RUN));  // R6
    AST_FLAG_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> $past(state == ST_IDLE));  // R7
endmodule

// File: tb/sim_drdy_capture_seq.sv
// Self-checking bench with a behavioural cycle model compared every clock.
module sim_drdy_capture_seq;
    localparam int F = 96;
    localparam int H = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         drdy_n = 1'b1;
    logic         miso = 1'b0;
    logic         sclk, cs_n, rx_done;
    logic [F-1:0] rx_word;

    int vectors = 0;
    int fails = 0;
    int ndone = 0;
    int rises = 0;
    int cycles = 0;
    bit ended = 0;

    // Model state: 0 rest, 1 flag set, 2 burst, 3 done.
    int           mode = 0;
    int           t = 0;
    logic [F-1:0] mword = '0;
    logic         h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
    logic         prev_sclk = 1'b0;
    int unsigned  lfsr = 32'h1ACE_B00C;

    drdy_capture_seq u0 (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .rx_word(rx_word), .rx_done(rx_done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [F-1:0] act, input logic [F-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            mode = 0; t = 0; mword = '0;
            h1 = 1'b1; h2 = 1'b1; h3 = 1'b1;
        end else begin
            case (mode)
                0: if (h3 && !h2) mode = 1;
                1: begin mode = 2; t = 0; end
                2: begin
                    t++;
                    if (t % (2*H) == H) mword = {mword[F-2:0], miso};
                    if (t == 2*H*F) mode = 3;
                end
                default: mode = 0;
            endcase
            h3 = h2; h2 = h1; h1 = drdy_n;
        end
    end

    // Compare away from the active edge; miso changes here too.
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(cs_n == (mode != 2), "R2", "cs_n", F'(cs_n), F'(mode != 2));
            chk(sclk == (mode == 2 && (t % (2*H)) >= H), "R4", "sclk",
                F'(sclk), F'(mode == 2 && (t % (2*H)) >= H));
            chk(rx_done == (mode == 3), "R6", "rx_done", F'(rx_done), F'(mode == 3));
            chk(rx_word == mword, "R5", "rx_word", rx_word, mword);
            chk(!(cs_n && sclk), "R9", "sclk while deselected", F'(sclk), '0);
            if (sclk && !prev_sclk) rises++;
            if (rx_done) begin
                ndone++;
                chk(rises == F, "R4", "sclk rises per burst", F'(rises), F'(F));
                rises = 0;
            end
            prev_sclk = sclk;
        end
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA300_0001 : 32'h0);
        miso <= lfsr[0];
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000 && !ended) begin
            chk(1'b0, "R2", "watchdog expired", '0, '1);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        chk(cs_n == 1'b1, "R1", "reset cs_n", F'(cs_n), F'(1));
        chk(sclk == 1'b0, "R1", "reset sclk", F'(sclk), '0);
        chk(rx_done == 1'b0, "R1", "reset rx_done", F'(rx_done), '0);
        chk(rx_word == '0, "R1", "reset rx_word", rx_word, '0);
        rst_n <= 1'b1;
        idle(1);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "first cycle after reset",
            F'({cs_n, sclk}), F'(2'b10));
        idle(10);

        // R2: short low pulse, latency of chip select.
        drdy_n <= 1'b0;
        idle(1);
        drdy_n <= 1'b1;
        idle(2);
        chk(cs_n == 1'b1, "R2", "cs_n before third edge", F'(cs_n), F'(1));
        idle(1);
        chk(cs_n == 1'b0, "R2", "cs_n after third edge", F'(cs_n), '0);
        idle(450);
        chk(ndone == 1, "R2", "one burst from pulse", F'(ndone), F'(1));

        // R3: level held low across more than two burst lengths.
        drdy_n <= 1'b0;
        idle(1000);
        chk(ndone == 2, "R3", "held low gives one burst", F'(ndone), F'(2));
        drdy_n <= 1'b1;
        idle(20);

        // R7: edges in the middle of a burst are ignored.
        drdy_n <= 1'b0;
        idle(100);
        drdy_n <= 1'b1;
        idle(10);
        drdy_n <= 1'b0;
        idle(10);
        drdy_n <= 1'b1;
        idle(10);
        drdy_n <= 1'b0;
        idle(5);
        drdy_n <= 1'b1;
        idle(600);
        chk(ndone == 3, "R7", "mid-burst edges ignored", F'(ndone), F'(3));

        // R8: edge at the done cycle re-arms after rest.
        drdy_n <= 1'b0;
        idle(2);
        drdy_n <= 1'b1;
        while (!rx_done) @(negedge clk);
        drdy_n <= 1'b0;
        idle(2);
        drdy_n <= 1'b1;
        idle(450);
        chk(ndone == 5, "R8", "burst after done-cycle edge", F'(ndone), F'(5));
        idle(20);
        finish_run();
    end
endmodule